// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits at the front of a multithreaded execution pipeline. Each cycle it selects at most one resident warp to issue. A warp is a group of 32 threads, and a thread block of N threads occupies N/32 warps. With the default size of 24 entries, the table holds the 768 threads that can be resident at once. All threads of the selected warp execute the same instruction. Each table entry holds three things: an occupancy bit, the tag of the thread block that owns the warp, and an operands-ready flag. The dependency tracking logic outside the block writes that flag.

Allocation and retirement events fill and free table entries. Per-warp write strobes update the ready flags. A stall input from the downstream pipeline blocks issue. A warp is eligible when its entry is occupied and its ready flag is set. Among the eligible warps, selection uses a rotating priority that starts at the warp just after the last one issued. No warp can starve, and a different warp can issue in the very next cycle with no idle cycle between.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, every entry is empty and `issue_valid` is 0.
- R2: An allocation event sets the entry's occupancy bit, stores `alloc_tag` and clears its ready flag. A retire event clears both the occupancy bit and the ready flag. When both events name the same entry in the same cycle, the retire event wins. Each event takes effect at the next clock edge.
- R3: When `rdy_we[i]` is 1, the ready flag of warp i takes the value of `rdy_val[i]` at the next clock edge. This write overrides the clear caused by an allocation to the same warp, but not the clear caused by a retire. When `rdy_we[i]` is 0, the flag is left unchanged.
- R4: Only an eligible warp can be issued, meaning one that is occupied and ready. `issue_warp` is always below NUM_WARPS whenever `issue_valid` is 1.
- R5: The search starts at the warp one above the last issued warp and wraps from NUM_WARPS-1 to 0. The lowest eligible index along that order is selected. After reset, warp 0 has the highest priority.
- R6: Selection is combinational on the table state. If a warp is eligible and `stall` is 0, `issue_valid` is 1 in that same cycle. Consecutive cycles may issue different warps with no gap between them.
- R7: While `stall` is 1, `issue_valid` is 0 and the round-robin position does not move.
- R8: When no warp is eligible, `issue_valid` is 0.
- R9: `issue_tag` equals the block tag stored for the warp on `issue_warp` whenever `issue_valid` is 1.
- R10: Allocation or retire events whose index is NUM_WARPS or above change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation event strobe |
| alloc_warp | input | IDX_W | Entry index to allocate |
| alloc_tag | input | TAG_W | Thread block tag for the allocated warp |
| retire_valid | input | 1 | Retire event strobe |
| retire_warp | input | IDX_W | Entry index to free |
| rdy_we | input | NUM_WARPS | Per-warp ready flag write enable |
| rdy_val | input | NUM_WARPS | Per-warp ready flag write value |
| stall | input | 1 | Downstream stall; blocks issue this cycle |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_warp | output | IDX_W | Index of the issued warp |
| issue_tag | output | TAG_W | Block tag of the issued warp |

## Verification
Table events and ready writes take effect at the clock edge that samples them. The issue outputs respond in the cycle right after that edge. `stall` acts on the outputs within the same cycle. The round-robin position moves at the edge that ends an issuing cycle, so it shapes the next cycle's pick. The bench drives inputs on the falling edge and samples outputs 1 ns later. It compares them against a model whose state advances exactly once per rising edge. Every expected pick is therefore computed from the state and the same-cycle stall that the design sees.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  // Threads grouped into one warp
  localparam int unsigned THREADS_PER_WARP = 32;
  // Default resident warp count (768 threads)
  localparam int unsigned DEF_WARPS        = 24;
  // Default width of a thread block tag
  localparam int unsigned DEF_TAG_W        = 4;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wsched_table.sv
module wsched_table #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned TAG_W     = 4,
  parameter int unsigned IDX_W     = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            alloc_valid,
  input  logic [IDX_W-1:0]                alloc_warp,
  input  logic [TAG_W-1:0]                alloc_tag,
  input  logic                            retire_valid,
  input  logic [IDX_W-1:0]                retire_warp,
  input  logic [NUM_WARPS-1:0]            rdy_we,
  input  logic [NUM_WARPS-1:0]            rdy_val,
  output logic [NUM_WARPS-1:0]            elig,
  output logic [NUM_WARPS-1:0][TAG_W-1:0] tags
);
  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_entry
    logic occ_q, occ_d, rdy_q, rdy_d;
    logic [TAG_W-1:0] tag_q;
    logic alloc_hit, retire_hit, tag_en;

    assign alloc_hit  = alloc_valid  && (int'(alloc_warp)  == g);
    assign retire_hit = retire_valid && (int'(retire_warp) == g);
    assign tag_en     = alloc_hit && !retire_hit;

    always_comb begin
      occ_d = occ_q;
      if (retire_hit)     occ_d = 1'b0;
      else if (alloc_hit) occ_d = 1'b1;

      rdy_d = rdy_q;
      if (retire_hit)     rdy_d = 1'b0;
      else if (rdy_we[g]) rdy_d = rdy_val[g];
      else if (alloc_hit) rdy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_q <= 1'b0;
        rdy_q <= 1'b0;
      end else begin
        occ_q <= occ_d;
        rdy_q <= rdy_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q <= '0;
      else if (tag_en) tag_q <= alloc_tag;
    end

    assign elig[g] = occ_q && rdy_q;
    assign tags[g] = tag_q;
  end
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [NUM_WARPS-1:0] elig,
  input  logic [IDX_W-1:0]     last,
  output logic                 found,
  output logic [IDX_W-1:0]     pick
);
  logic             upper_found, any_found;
  logic [IDX_W-1:0] upper_idx, any_idx;

  // Descending scan leaves the lowest index; the upper search covers
  // indices strictly above the last issued warp, the other wraps.
  always_comb begin
    upper_found = 1'b0;
    upper_idx   = '0;
    any_found   = 1'b0;
    any_idx     = '0;
    for (int i = NUM_WARPS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any_found = 1'b1;
        any_idx   = IDX_W'(i);
        if (i > int'(last)) begin
          upper_found = 1'b1;
          upper_idx   = IDX_W'(i);
        end
      end
    end
  end

  assign found = any_found;
  assign pick  = upper_found ? upper_idx : any_idx;
endmodule

// File: rtl/wsched_ptr.sv
module wsched_ptr #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [IDX_W-1:0] adv_val,
  output logic [IDX_W-1:0] last_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WARPS - 1);

  logic [IDX_W-1:0] last_d;

  always_comb begin
    last_d = last_q;
    if (adv_en) last_d = adv_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= LAST_IDX;
    else        last_q <= last_d;
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = DEF_WARPS,
  parameter int unsigned TAG_W     = DEF_TAG_W,
  localparam int unsigned IDX_W    = idx_width(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  input  logic [IDX_W-1:0]     alloc_warp,
  input  logic [TAG_W-1:0]     alloc_tag,
  input  logic                 retire_valid,
  input  logic [IDX_W-1:0]     retire_warp,
  input  logic [NUM_WARPS-1:0] rdy_we,
  input  logic [NUM_WARPS-1:0] rdy_val,
  input  logic                 stall,
  output logic                 issue_valid,
  output logic [IDX_W-1:0]     issue_warp,
  output logic [TAG_W-1:0]     issue_tag
);
  logic [NUM_WARPS-1:0]            elig_vec;
  logic [NUM_WARPS-1:0][TAG_W-1:0] tag_tbl;
  logic                            pick_found;
  logic [IDX_W-1:0]                pick_idx;
  logic [IDX_W-1:0]                last_q;

  wsched_table #(.NUM_WARPS(NUM_WARPS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_warp   (alloc_warp),
    .alloc_tag    (alloc_tag),
    .retire_valid (retire_valid),
    .retire_warp  (retire_warp),
    .rdy_we       (rdy_we),
    .rdy_val      (rdy_val),
    .elig         (elig_vec),
    .tags         (tag_tbl)
  );

  wsched_rr_pick #(.NUM_WARPS(NUM_WARPS), .IDX_W(IDX_W)) u_pick (
    .elig  (elig_vec),
    .last  (last_q),
    .found (pick_found),
    .pick  (pick_idx)
  );

  assign issue_valid = pick_found && !stall;
  assign issue_warp  = pick_idx;
  assign issue_tag   = tag_tbl[pick_idx];

  wsched_ptr #(.NUM_WARPS(NUM_WARPS), .IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_en  (issue_valid),
    .adv_val (pick_idx),
    .last_q  (last_q)
  );
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned IDX_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 stall,
  input logic [NUM_WARPS-1:0] elig_vec,
  input logic [IDX_W-1:0]     last_q,
  input logic                 issue_valid,
  input logic [IDX_W-1:0]     issue_warp
);
  AST_ISSUE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (int'(issue_warp) < NUM_WARPS)); // R4
  AST_ISSUE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> elig_vec[issue_warp]); // R4
  AST_NO_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|elig_vec) && !stall) |-> issue_valid); // R6
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !issue_valid); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $stable(last_q)); // R7
  AST_PTR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (last_q == $past(issue_warp))); // R5
  AST_NONE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_vec == '0) |-> !issue_valid); // R8
endmodule

bind warp_issue_sched wsched_chk #(.NUM_WARPS(NUM_WARPS), .IDX_W(IDX_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stall       (stall),
  .elig_vec    (elig_vec),
  .last_q      (last_q),
  .issue_valid (issue_valid),
  .issue_warp  (issue_warp)
);

// File: tb/test_warp_issue_sched.sv
`timescale 1ns/1ps
module test_warp_issue_sched;
  localparam int N  = 6;
  localparam int TW = 3;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          alloc_valid, retire_valid, stall;
  logic [IW-1:0] alloc_warp, retire_warp;
  logic [TW-1:0] alloc_tag;
  logic [N-1:0]  rdy_we, rdy_val;
  logic          issue_valid;
  logic [IW-1:0] issue_warp;
  logic [TW-1:0] issue_tag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit          m_occ [N];
  bit          m_rdy [N];
  int          m_tag [N];
  int          m_last;

  always #2.5 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(N), .TAG_W(TW)) i_warp_issue_sched (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_warp(alloc_warp),
    .alloc_tag(alloc_tag), .retire_valid(retire_valid), .retire_warp(retire_warp),
    .rdy_we(rdy_we), .rdy_val(rdy_val), .stall(stall), .issue_valid(issue_valid),
    .issue_warp(issue_warp), .issue_tag(issue_tag));

  function automatic int exp_pick();
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (m_last + k) % N;
      if (m_occ[j] && m_rdy[j]) return j;
    end
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, sample 1 ns later, advance model at the rising edge.
  task automatic step(input bit av, input int aw, input int at, input bit rv, input int rw,
                      input logic [N-1:0] we, input logic [N-1:0] val, input bit st);
    int  p;
    bit  ev;
    string req;
    alloc_valid = av; alloc_warp = IW'(aw); alloc_tag = TW'(at);
    retire_valid = rv; retire_warp = IW'(rw);
    rdy_we = we; rdy_val = val; stall = st;
    #1;
    p  = exp_pick();
    ev = (p >= 0) && !st;
    if (st)          req = "R7";
    else if (p < 0)  req = "R8";
    else             req = "R5/R6";
    chk(req, int'(issue_valid), int'(ev));
    if (ev) begin
      chk("R5", int'(issue_warp), p);
      chk("R9", int'(issue_tag), m_tag[p]);
      m_last = p;
    end
    for (int i = 0; i < N; i++) begin
      bit ah, rh;
      ah = av && (aw == i);
      rh = rv && (rw == i);
      if (rh) begin m_occ[i] = 0; m_rdy[i] = 0; end
      else begin
        if (ah) begin m_occ[i] = 1; m_tag[i] = at; end
        if (we[i]) m_rdy[i] = val[i];
        else if (ah) m_rdy[i] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 0; alloc_warp = '0; alloc_tag = '0;
    retire_valid = 0; retire_warp = '0; rdy_we = '0; rdy_val = '0; stall = 0;
    for (int i = 0; i < N; i++) begin m_occ[i] = 0; m_rdy[i] = 0; m_tag[i] = 0; end
    m_last = N - 1;
    repeat (3) @(negedge clk);
    chk("R1", int'(issue_valid), 0);            // R1 during reset
    rst_n = 1'b1;
    // R1: first cycle out of reset, R10: out-of-range allocate with all ready
    step(1, 7, 5, 0, 0, '1, '1, 0);
    step(1, 6, 2, 0, 0, '1, '1, 0);             // R10 nothing became occupied
    step(0, 0, 0, 0, 0, '0, '0, 0);
    // R2: allocate every warp; ready cleared by allocate, so no issue (R8)
    for (int i = 0; i < N; i++) step(1, i, (i * 3 + 1) % 8, 0, 0, '0, '0, 0);
    step(0, 0, 0, 0, 0, '0, '0, 0);
    // R3/R5/R6/R7/R8/R9: sweep every ready pattern, with stalls mixed in
    for (int p = 0; p < 64; p++)
      for (int r = 0; r < 3; r++)
        step(0, 0, 0, 0, 0, '1, N'(p), (p % 5 == 0) && (r == 1));
    // R3: partial write enables keep untouched flags
    step(0, 0, 0, 0, 0, '1, '1, 0);
    step(0, 0, 0, 0, 0, 6'b000101, 6'b000000, 0);
    for (int r = 0; r < 5; r++) step(0, 0, 0, 0, 0, '0, '0, 0);
    // R2: retire and allocate on the same warp; retire wins
    step(1, 2, 6, 1, 2, '0, '0, 0);
    step(0, 0, 0, 0, 0, '1, '1, 0);
    for (int r = 0; r < 7; r++) step(0, 0, 0, 0, 0, '0, '0, 0);
    // R10: out-of-range retire leaves all warps intact
    step(0, 0, 0, 1, 7, '0, '0, 0);
    for (int r = 0; r < 6; r++) step(0, 0, 0, 0, 0, '0, '0, 0);
    // R3: ready write overrides allocate clear; new tag seen on issue (R9)
    step(1, 2, 7, 0, 0, 6'b000100, 6'b000100, 0);
    for (int r = 0; r < 6; r++) step(0, 0, 0, 0, 0, '0, '0, 0);
    // R2: retire everything, then no issue
    for (int i = 0; i < N; i++) step(0, 0, 0, 1, i, '0, '0, 0);
    step(0, 0, 0, 0, 0, '0, '0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule